// File: doc/BRIEF.md
# Line-Interleaved Banked Memory Controller

This block takes read and write requests on a single valid/ready request port and spreads them over a set of independent memory banks held inside it as register arrays. Each 32-byte line of the address space belongs to one bank, and neighbouring lines belong to neighbouring banks. The mapping wraps after the last bank, so a stream that walks memory line by line visits every bank in turn.

Every bank has two timing figures. The access latency is the number of cycles until read data comes back. The cycle time is the longer window during which the bank cannot take another request. A request whose bank is still inside its window is held at the head of the port, and `req_ready` stays low. Requests to idle banks are accepted on consecutive cycles. The block never reorders requests and never lets a later request pass a stalled one, so a stalled request blocks the port.

Read data returns with its tag, in issue order. Writes return nothing. Two counters show the effect of the access pattern: a stall counter and a per-bank busy-cycle counter. A line-stride walk shows no stalls. A walk whose stride equals the number of banks stalls on every request after the first.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: The bank is selected by address bits [6:5], which gives 32-byte lines over 4 banks. Addresses 0 and 128 therefore land in the same bank 0, and address 32 lands in bank 1.
- R2: Inside a bank, the 32-bit word is indexed by {addr[9:7], addr[4:2]}. Distinct word-aligned addresses keep distinct data.
- R3: A bank that accepts a request at a clock edge takes no other request until CYC_TIME edges later (default 4). A request to that bank is accepted exactly CYC_TIME cycles after the earlier one when it is waiting.
- R4: `req_ready` is low only while the bank addressed by `req_addr` is inside its window. Requests to idle banks are accepted on back-to-back cycles, so a walk of 8 consecutive lines has zero stall cycles.
- R5: A request transfers on a rising edge where `req_valid` and `req_ready` are both high. A stalled request stays at the head and is accepted in order, never overtaken.
- R6: A read accepted at edge k raises `rsp_valid` for one cycle, starting ACC_LAT-1 edges after k (default 2). It carries the request's `req_tag` and the word stored at that address. Responses leave in acceptance order.
- R7: A write (`req_write`=1) produces no response, yet it holds its bank for the full CYC_TIME window.
- R8: `stall_count` rises by one on every cycle with `req_valid` high and `req_ready` low. After idle, a burst of 4 writes to lines 4 apart adds 3×(CYC_TIME-1) = 9.
- R9: The field of `busy_cycles` for bank b (bits [b*16 +: 16]) counts every cycle from the accepting edge through the window. An isolated access adds exactly CYC_TIME to it.
- R10: After reset, `req_ready` is high, `rsp_valid` is low, and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| req_tag | input | 4 | Tag returned with read data |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_tag | output | 4 | Tag of the responding read |
| rsp_data | output | 32 | Read data |
| stall_count | output | 16 | Cycles with a request held back |
| busy_cycles | output | 64 | Per-bank busy-cycle counters, 16 bits each |

## Verification
Each read is checked at the negative edge in which its response is due. That edge is computed as the acceptance cycle plus ACC_LAT, and the tag, the data and that exact cycle are compared. A response in any other cycle, or one for a write, counts as a failure. The bench keeps its own per-bank record of the last acceptance cycle and derives from it the number of stall cycles each request should see. It compares that with the cycles `req_ready` stays low. Counter deltas are read only after the affected windows have fully closed, CYC_TIME or more cycles after the last acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;
  localparam int unsigned DEF_BANKS = 4;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned NUM_BANKS = ilv_pkg::DEF_BANKS,
  parameter int unsigned LINE_BYTES = ilv_pkg::DEF_LINE_BYTES,
  parameter int unsigned WORD_BYTES = ilv_pkg::DEF_WORD_BYTES,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned SEL_W = $clog2(NUM_BANKS),
  localparam int unsigned WOFF_W = $clog2(WORD_BYTES),
  localparam int unsigned IDX_W = ADDR_W - SEL_W - WOFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  bank_sel,
  output logic [IDX_W-1:0]  word_idx
);
  // line number low bits pick the bank; the rest plus the in-line word offset index it
  assign bank_sel = addr[OFF_W +: SEL_W];
  assign word_idx = {addr[ADDR_W-1:OFF_W+SEL_W], addr[OFF_W-1:WOFF_W]};
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CYC_TIME = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned DEPTH = 1 << IDX_W,
  localparam int unsigned TMR_W = $clog2(CYC_TIME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  bcnt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [TMR_W-1:0]  tmr;

  always_ff @(posedge clk) begin
    if (issue && wr) mem[idx] <= wdata;
  end
  assign rdata = mem[idx];

  // window timer: the accepting cycle plus CYC_TIME-1 following cycles
  always_ff @(posedge clk) begin
    if (!rst_n)             tmr <= '0;
    else if (issue)         tmr <= TMR_W'(CYC_TIME - 1);
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end
  assign busy = (tmr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              bcnt <= '0;
    else if (issue || busy)  bcnt <= bcnt + 1'b1;
  end

  AST_NO_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !busy); // R3
  generate
    if (CYC_TIME > 1) begin : g_win
      AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> busy); // R3
    end
  endgenerate
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !busy) |=> $stable(bcnt)); // R9
endmodule

// File: rtl/ilv_rsp_pipe.sv
module ilv_rsp_pipe #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  logic              sv [LAT];
  logic [TAG_W-1:0]  st [LAT];
  logic [DATA_W-1:0] sd [LAT];

  genvar i;
  generate
    for (i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sv[0] <= 1'b0;
          else        sv[0] <= in_valid;
          st[0] <= in_tag;
          sd[0] <= in_data;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sv[i] <= 1'b0;
          else        sv[i] <= sv[i-1];
          st[i] <= st[i-1];
          sd[i] <= sd[i-1];
        end
      end
    end
  endgenerate

  assign out_valid = sv[LAT-1];
  assign out_tag   = st[LAT-1];
  assign out_data  = sd[LAT-1];
endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W = 4,
  parameter int unsigned NUM_BANKS = ilv_pkg::DEF_BANKS,
  parameter int unsigned LINE_BYTES = ilv_pkg::DEF_LINE_BYTES,
  parameter int unsigned ACC_LAT = 2,
  parameter int unsigned CYC_TIME = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned SEL_W = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W = ADDR_W - SEL_W - $clog2(DATA_W / 8)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       rsp_valid,
  output logic [TAG_W-1:0]           rsp_tag,
  output logic [DATA_W-1:0]          rsp_data,
  output logic [CNT_W-1:0]           stall_count,
  output logic [NUM_BANKS*CNT_W-1:0] busy_cycles
);
  import ilv_pkg::*;

  initial begin
    assert (ACC_LAT >= 1 && CYC_TIME >= ACC_LAT)
      else $error("cycle time must be at least the access latency");
  end

  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  widx;
  logic [NUM_BANKS-1:0] busy_vec;
  logic [NUM_BANKS-1:0] issue_vec;
  logic [DATA_W-1:0] rd_vec [NUM_BANKS];
  logic              accept;
  op_e               op;

  ilv_addr_map #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .LINE_BYTES(LINE_BYTES), .WORD_BYTES(DATA_W / 8)
  ) u_map (
    .addr(req_addr), .bank_sel(sel), .word_idx(widx)
  );

  assign op        = req_write ? OP_WRITE : OP_READ;
  assign req_ready = !busy_vec[sel];
  assign accept    = req_valid && req_ready;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign issue_vec[b] = accept && (sel == SEL_W'(b));
      ilv_bank #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .CYC_TIME(CYC_TIME), .CNT_W(CNT_W)
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .issue(issue_vec[b]), .wr(op == OP_WRITE),
        .idx(widx), .wdata(req_wdata),
        .busy(busy_vec[b]), .rdata(rd_vec[b]),
        .bcnt(busy_cycles[b*CNT_W +: CNT_W])
      );
    end
  endgenerate

  // one acceptance per cycle and a fixed latency keep completions in issue order
  ilv_rsp_pipe #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(ACC_LAT)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(accept && (op == OP_READ)), .in_tag(req_tag), .in_data(rd_vec[sel]),
    .out_valid(rsp_valid), .out_tag(rsp_tag), .out_data(rsp_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       stall_count <= '0;
    else if (req_valid && !req_ready) stall_count <= stall_count + 1'b1;
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec)); // R1
  AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (stall_count != $past(stall_count))); // R8
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec == '0) |-> req_ready); // R4
endmodule

// File: tb/tb_ilv_bank_ctrl.sv
`timescale 1ns/1ps
module tb_ilv_bank_ctrl;
  localparam int ACC = 2;
  localparam int CYC = 4;
  localparam int CW  = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_tag = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_tag;
  logic [31:0] rsp_data;
  logic [CW-1:0] stall_count;
  logic [4*CW-1:0] busy_cycles;

  ilv_bank_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .stall_count(stall_count), .busy_cycles(busy_cycles)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // bench-side model built from the requirements
  logic [31:0] shadow [256];
  int last_acc [4];
  int q_tag [64], q_cyc [64];
  logic [31:0] q_dat [64];
  int q_head = 0, q_tail = 0, rsp_seen = 0;

  // response monitor (R6, R7)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      rsp_seen++;
      if (q_head == q_tail) begin
        chk(0, "R7 unexpected response", rsp_tag, 0);
      end else begin
        chk(rsp_tag == 4'(q_tag[q_head]), "R6 tag order", rsp_tag, q_tag[q_head]);
        chk(rsp_data == q_dat[q_head], "R6/R2 data", rsp_data, q_dat[q_head]);
        chk(cyc == q_cyc[q_head], "R6 latency", cyc, q_cyc[q_head]);
        q_head++;
      end
    end
  end

  task automatic issue(input bit w, input logic [9:0] a, input logic [31:0] d,
                       input logic [3:0] t, output int stalls, output int exp_st);
    int bk;
    int c;
    bk = int'(a[6:5]); // R1 mapping
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_tag = t;
    #1;
    exp_st = last_acc[bk] + CYC - cyc;
    if (exp_st < 0) exp_st = 0;
    stalls = 0;
    while (!req_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    c = cyc;
    last_acc[bk] = c;
    if (w) shadow[a[9:2]] = d;
    else begin
      q_tag[q_tail] = int'(t); q_dat[q_tail] = shadow[a[9:2]];
      q_cyc[q_tail] = c + ACC; q_tail++;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {write, addr[9:0], data[31:0], tag[3:0]}
  localparam logic [46:0] VEC [12] = '{
    {1'b1, 10'h000, 32'hA0A0_0001, 4'd0},
    {1'b1, 10'h020, 32'hB1B1_0002, 4'd1},
    {1'b1, 10'h040, 32'hC2C2_0003, 4'd2},
    {1'b1, 10'h060, 32'hD3D3_0004, 4'd3},
    {1'b1, 10'h084, 32'hE4E4_0005, 4'd4},
    {1'b0, 10'h000, 32'h0,         4'd5},
    {1'b0, 10'h020, 32'h0,         4'd6},
    {1'b0, 10'h084, 32'h0,         4'd7},
    {1'b0, 10'h040, 32'h0,         4'd8},
    {1'b1, 10'h104, 32'hF5F5_0006, 4'd9},
    {1'b0, 10'h104, 32'h0,         4'd10},
    {1'b0, 10'h060, 32'h0,         4'd11}
  };

  initial begin
    int st, ex, s0, b0, r0;
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    for (int i = 0; i < 4; i++) last_acc[i] = -100;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid after reset", rsp_valid, 0);
    chk(stall_count == 0, "R10 stall_count after reset", stall_count, 0);
    chk(busy_cycles == 0, "R10 busy_cycles after reset", busy_cycles, 0);

    // vector table: stall cycles per request (R3, R4, R5)
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][46], VEC[i][45:36], VEC[i][35:4], VEC[i][3:0], st, ex);
      chk(st == ex, $sformatf("R3/R4 stall cycles vec %0d", i), st, ex);
    end
    idle(CYC + 2);

    // R1 wrap: 0x000 and 0x080 share bank 0
    issue(1, 10'h000, 32'h1111_0000, 4'd12, st, ex);
    issue(1, 10'h080, 32'h2222_0000, 4'd13, st, ex);
    chk(st == CYC - 1, "R1 wrap to bank 0 stalls", st, CYC - 1);
    issue(0, 10'h000, 32'h0, 4'd14, st, ex); // R2 distinct words
    idle(CYC + 2);

    // R4 stride-1 burst of 8 lines: zero stalls
    s0 = int'(stall_count);
    for (int i = 0; i < 8; i++) issue(1, 10'(32'h110 + 32 * i), 32'h5000 + i, 4'd0, st, ex);
    idle(CYC + 2);
    chk(int'(stall_count) - s0 == 0, "R4 stride-1 stall total", stall_count - s0, 0);

    // R8 stride-4 lines: 3 stalls per request after the first
    s0 = int'(stall_count);
    for (int i = 0; i < 4; i++) issue(1, 10'(32'h008 + 128 * i), 32'h7000 + i, 4'd0, st, ex);
    idle(CYC + 2);
    chk(int'(stall_count) - s0 == 3 * (CYC - 1), "R8 stride-4 write stalls",
        stall_count - s0, 3 * (CYC - 1));
    s0 = int'(stall_count);
    for (int i = 0; i < 4; i++) issue(0, 10'(32'h008 + 128 * i), 32'h0, 4'(i), st, ex);
    idle(CYC + 2);
    chk(int'(stall_count) - s0 == 3 * (CYC - 1), "R8/R3 stride-4 read stalls",
        stall_count - s0, 3 * (CYC - 1));

    // R9 and R7: isolated write to bank 1 adds CYC busy cycles and no response
    b0 = int'(busy_cycles[CW +: CW]);
    r0 = rsp_seen;
    issue(1, 10'h020, 32'h9999_0000, 4'd15, st, ex);
    idle(CYC + 3);
    chk(int'(busy_cycles[CW +: CW]) - b0 == CYC, "R9 busy cycles per access",
        busy_cycles[CW +: CW] - b0, CYC);
    chk(rsp_seen == r0, "R7 write gives no response", rsp_seen, r0);
    issue(0, 10'h020, 32'h0, 4'd3, st, ex); // R7 write still landed
    idle(ACC + 3);
    chk(q_head == q_tail, "R6 all read responses delivered", q_head, q_tail);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule